// File: doc/BRIEF.md
# SCSI Initiator Register Interface

This block is the processor-facing register file of a SCSI bus initiator. A host reaches it through an 8-bit data path and a 3-bit address. At the same address, a read and a write reach different registers. The read side shows the live bus data, the live control lines, the stored command and mode registers, and a status byte. The write side loads an output data latch, an initiator command register, a mode register and an expected-phase register.

The bus is open-collector. Each control line and the data bus therefore appear twice: once as a drive output and once as a sense input. The initiator command register turns the RST, ACK, BSY, SEL and ATN drive lines on and off directly. Its data-enable bit places the output latch on the bus. The status byte holds a phase-match flag. This flag compares the live MSG, C/D and I/O lines against the expected-phase register at every moment.

Parity, interrupts, DMA transfers, arbitration and target operation have no logic here. Their flags read as zero.

Top module: `scsi_init_regs`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stored register clears and every drive output goes low, including `bus_data_oe` and `bus_data_o`. Afterwards, reads at offsets 1, 2 and 3 return 0x00.
- R2: A read at offset 0 returns `bus_data_i` unchanged. A read at offset 4 returns {RST, BSY, REQ, MSG, C/D, I/O, SEL, parity} from bit 7 down to bit 0. Every bit comes from the live sense inputs in the same cycle.
- R3: A write at offset 1 sets the drive outputs from the next clock onward: bit 7 drives RST, bit 4 ACK, bit 3 BSY, bit 2 SEL and bit 1 ATN. The lines hold their value until the next write at offset 1.
- R4: Bits 6 and 5 of the initiator command register always read 0. Writing ones to them changes no stored bit and no drive output.
- R5: A write at offset 0 loads the output latch. `bus_data_oe` equals initiator command bit 0. `bus_data_o` shows the latch while that bit is set and shows 0x00 otherwise. Setting the bit drives a value that was loaded earlier. A latch write made while the bit is set drives the new value from the next clock.
- R6: Writes at offset 2 (mode) and offset 3 (expected phase) store all 8 bits. Reads at the same offsets return those bits.
- R7: Bit 3 of the offset-5 read is 1 exactly when MSG, C/D and I/O equal expected-phase bits 2, 1 and 0 respectively. It follows changes on the live lines in the same cycle, and changes to the expected phase from the clock after the write.
- R8: In the offset-5 read, bit 1 is the live ATN sense and bit 0 is the live ACK sense. Bits 7 to 4 and bit 2 read 0.
- R9: Reads at offsets 6 and 7 return 0x00. Writes at offsets 4 to 7 change no register and no drive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| bus_data_i | input | 8 | Sensed bus data |
| bus_rst_i | input | 1 | Sensed RST |
| bus_bsy_i | input | 1 | Sensed BSY |
| bus_req_i | input | 1 | Sensed REQ |
| bus_msg_i | input | 1 | Sensed MSG |
| bus_cd_i | input | 1 | Sensed C/D |
| bus_io_i | input | 1 | Sensed I/O |
| bus_sel_i | input | 1 | Sensed SEL |
| bus_par_i | input | 1 | Sensed data parity |
| bus_atn_i | input | 1 | Sensed ATN |
| bus_ack_i | input | 1 | Sensed ACK |
| bus_data_o | output | 8 | Data drive value |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rst_o | output | 1 | Drive RST |
| bus_ack_o | output | 1 | Drive ACK |
| bus_bsy_o | output | 1 | Drive BSY |
| bus_sel_o | output | 1 | Drive SEL |
| bus_atn_o | output | 1 | Drive ACK-adjacent ATN line |

## Verification
The assertions take three things for granted about the inputs:
- `addr` and `wdata` stay steady around each rising edge.
- `wr_en` lasts exactly one cycle per write.
- The sense inputs do not change at the edge itself.

The stimulus meets all three by changing inputs only on falling edges. The bench models the wired bus by OR-ing the drive outputs with its own target-side lines. The sensed ATN and ACK therefore carry the block's own drive, which is what real hardware does. The bench moves the phase lines only between reads, so every read of the phase-match bit sees settled values.

// File: rtl/scsi_init_regs.sv
module scsi_init_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] bus_data_i,
  input  logic       bus_rst_i,
  input  logic       bus_bsy_i,
  input  logic       bus_req_i,
  input  logic       bus_msg_i,
  input  logic       bus_cd_i,
  input  logic       bus_io_i,
  input  logic       bus_sel_i,
  input  logic       bus_par_i,
  input  logic       bus_atn_i,
  input  logic       bus_ack_i,
  output logic [7:0] bus_data_o,
  output logic       bus_data_oe,
  output logic       bus_rst_o,
  output logic       bus_ack_o,
  output logic       bus_bsy_o,
  output logic       bus_sel_o,
  output logic       bus_atn_o
);
  localparam logic [7:0] CMD_WMASK = 8'h9F;

  logic [7:0] out_latch, cmd_q, mode_q, phase_q;
  logic       phase_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= '0;
      cmd_q     <= '0;
      mode_q    <= '0;
      phase_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: out_latch <= wdata;
        3'd1: cmd_q     <= wdata & CMD_WMASK;
        3'd2: mode_q    <= wdata;
        3'd3: phase_q   <= wdata;
        default: ;
      endcase
    end
  end

  assign bus_rst_o   = cmd_q[7];
  assign bus_ack_o   = cmd_q[4];
  assign bus_bsy_o   = cmd_q[3];
  assign bus_sel_o   = cmd_q[2];
  assign bus_atn_o   = cmd_q[1];
  assign bus_data_oe = cmd_q[0];
  assign bus_data_o  = cmd_q[0] ? out_latch : 8'h00;

  assign phase_hit = ({bus_msg_i, bus_cd_i, bus_io_i} == phase_q[2:0]);

  always_comb begin
    case (addr)
      3'd0: rdata = bus_data_i;
      3'd1: rdata = cmd_q;
      3'd2: rdata = mode_q;
      3'd3: rdata = phase_q;
      3'd4: rdata = {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i,
                     bus_cd_i, bus_io_i, bus_sel_i, bus_par_i};
      3'd5: rdata = {4'b0000, phase_hit, 1'b0, bus_atn_i, bus_ack_i};
      default: rdata = 8'h00;
    endcase
  end

  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!bus_data_oe && !bus_rst_o && !bus_ack_o && !bus_bsy_o &&
             !bus_sel_o && !bus_atn_o && bus_data_o == 8'h00));

  a_r3_cmd_drives: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1) |=>
      (bus_rst_o == $past(wdata[7]) && bus_ack_o == $past(wdata[4]) &&
       bus_bsy_o == $past(wdata[3]) && bus_sel_o == $past(wdata[2]) &&
       bus_atn_o == $past(wdata[1]) && bus_data_oe == $past(wdata[0])));

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 3'd1) |=>
      ($stable(bus_rst_o) && $stable(bus_ack_o) && $stable(bus_bsy_o) &&
       $stable(bus_sel_o) && $stable(bus_atn_o) && $stable(bus_data_oe)));

  a_r4_status_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == 3'd1) |-> (rdata[6:5] == 2'b00));

  a_r5_latch_follows_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && bus_data_oe && !(wr_en && addr == 3'd1)) |=>
      (bus_data_o == $past(wdata)));

  a_r7_mismatch_clears: assert property (@(posedge clk) disable iff (rst)
    (addr == 3'd5 && {bus_msg_i, bus_cd_i, bus_io_i} != phase_q[2:0]) |->
      !rdata[3]);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == 3'd5) |-> (rdata[7:4] == 4'h0 && !rdata[2]));
endmodule

// File: tb/sim_scsi_init_regs.sv
module sim_scsi_init_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] tgt_data = '0;
  logic t_rst = 0, t_bsy = 0, t_req = 0, t_msg = 0, t_cd = 0, t_io = 0;
  logic t_sel = 0, t_par = 0, t_atn = 0, t_ack = 0;
  logic [7:0] bus_data_o;
  logic bus_data_oe, bus_rst_o, bus_ack_o, bus_bsy_o, bus_sel_o, bus_atn_o;
  logic [7:0] s_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign s_data = bus_data_oe ? bus_data_o : tgt_data;

  scsi_init_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .bus_data_i(s_data),
    .bus_rst_i(t_rst | bus_rst_o), .bus_bsy_i(t_bsy | bus_bsy_o),
    .bus_req_i(t_req), .bus_msg_i(t_msg), .bus_cd_i(t_cd), .bus_io_i(t_io),
    .bus_sel_i(t_sel | bus_sel_o), .bus_par_i(t_par),
    .bus_atn_i(t_atn | bus_atn_o), .bus_ack_i(t_ack | bus_ack_o),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_rst_o(bus_rst_o), .bus_ack_o(bus_ack_o), .bus_bsy_o(bus_bsy_o),
    .bus_sel_o(bus_sel_o), .bus_atn_o(bus_atn_o));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [7:0] drives();
    return {bus_rst_o, 2'b00, bus_ack_o, bus_bsy_o, bus_sel_o, bus_atn_o, bus_data_oe};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    wr(3'd0, 8'h5A); wr(3'd1, 8'h9F); wr(3'd2, 8'h33); wr(3'd3, 8'h07);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 drives after reset", drives(), 8'h00);
    chk("R1 data drive after reset", bus_data_o, 8'h00);
    rd(3'd1, v); chk("R1 icmd read", v, 8'h00);
    rd(3'd2, v); chk("R1 mode read", v, 8'h00);
    rd(3'd3, v); chk("R1 phase read", v, 8'h00);
  endtask

  task automatic t_live_status();
    logic [7:0] v;
    @(negedge clk);
    tgt_data = 8'hC3;
    t_rst = 1; t_bsy = 0; t_req = 1; t_msg = 0; t_cd = 1; t_io = 0; t_sel = 1; t_par = 0;
    rd(3'd0, v); chk("R2 bus data read", v, 8'hC3);
    rd(3'd4, v); chk("R2 status pattern A", v, 8'hAA);
    t_rst = 0; t_bsy = 1; t_req = 0; t_msg = 1; t_cd = 0; t_io = 1; t_sel = 0; t_par = 1;
    tgt_data = 8'h3C;
    rd(3'd4, v); chk("R2 status pattern B", v, 8'h55);
    rd(3'd0, v); chk("R2 bus data follows", v, 8'h3C);
    t_bsy = 0; t_msg = 0; t_io = 0; t_par = 0; tgt_data = 8'h00;
  endtask

  task automatic t_icmd_drive();
    wr(3'd1, 8'h12);
    chk("R3 ACK+ATN drive", drives(), 8'h12);
    wr(3'd2, 8'hFF);
    chk("R3 hold across other write", drives(), 8'h12);
    wr(3'd1, 8'h8C);
    chk("R3 RST+BSY+SEL drive", drives(), 8'h8C);
    wr(3'd1, 8'h00);
    chk("R3 release", drives(), 8'h00);
  endtask

  task automatic t_icmd_ro();
    logic [7:0] v;
    wr(3'd1, 8'h60);
    rd(3'd1, v); chk("R4 status bits read zero", v, 8'h00);
    chk("R4 no drive from status bits", drives(), 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R4 writable bits only", v, 8'h9F);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_data_latch();
    wr(3'd0, 8'hA5);
    chk("R5 no drive while disabled", bus_data_o, 8'h00);
    chk("R5 oe low", {7'd0, bus_data_oe}, 8'h00);
    wr(3'd1, 8'h01);
    chk("R5 earlier latch driven", bus_data_o, 8'hA5);
    chk("R5 oe high", {7'd0, bus_data_oe}, 8'h01);
    wr(3'd0, 8'h3E);
    chk("R5 new latch while enabled", bus_data_o, 8'h3E);
    wr(3'd1, 8'h00);
    chk("R5 drive removed", bus_data_o, 8'h00);
  endtask

  task automatic t_mode_phase();
    logic [7:0] v;
    wr(3'd2, 8'hB6);
    wr(3'd3, 8'hE9);
    rd(3'd2, v); chk("R6 mode readback", v, 8'hB6);
    rd(3'd3, v); chk("R6 phase readback", v, 8'hE9);
  endtask

  task automatic t_phase_match();
    logic [7:0] v;
    wr(3'd3, 8'h05);
    t_msg = 1; t_cd = 0; t_io = 1;
    rd(3'd5, v); chk("R7 match msg/io", v & 8'h08, 8'h08);
    t_cd = 1;
    rd(3'd5, v); chk("R7 mismatch on C/D change", v & 8'h08, 8'h00);
    wr(3'd3, 8'h07);
    rd(3'd5, v); chk("R7 match after phase write", v & 8'h08, 8'h08);
    t_msg = 0;
    rd(3'd5, v); chk("R7 mismatch on MSG", v & 8'h08, 8'h00);
    t_cd = 0; t_io = 0;
    wr(3'd3, 8'hF8);
    rd(3'd5, v); chk("R7 zero phase, upper bits ignored", v, 8'h08);
  endtask

  task automatic t_bas_live();
    logic [7:0] v;
    wr(3'd3, 8'h01);
    t_atn = 1;
    rd(3'd5, v); chk("R8 ATN live", v, 8'h02);
    t_atn = 0; t_ack = 1;
    rd(3'd5, v); chk("R8 ACK live", v, 8'h01);
    t_ack = 0;
    wr(3'd1, 8'h12);
    rd(3'd5, v); chk("R8 own drive sensed", v, 8'h03);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(3'd0, 8'h11); wr(3'd1, 8'h08); wr(3'd2, 8'h22); wr(3'd3, 8'h44);
    for (int a = 4; a < 8; a++) wr(a[2:0], 8'hFF);
    rd(3'd6, v); chk("R9 offset 6 zero", v, 8'h00);
    rd(3'd7, v); chk("R9 offset 7 zero", v, 8'h00);
    chk("R9 drives unchanged", drives(), 8'h08);
    rd(3'd1, v); chk("R9 icmd unchanged", v, 8'h08);
    rd(3'd2, v); chk("R9 mode unchanged", v, 8'h22);
    rd(3'd3, v); chk("R9 phase unchanged", v, 8'h44);
    wr(3'd1, 8'h01);
    chk("R9 latch unchanged", bus_data_o, 8'h11);
    wr(3'd1, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_live_status();
    t_icmd_drive();
    t_icmd_ro();
    t_data_latch();
    t_mode_phase();
    t_phase_match();
    t_bas_live();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule